// File: doc/BRIEF.md
# Dual-Set GPIO Blink Generator

This block produces two free-running square-like waveforms, set A and set B, each shaped by two programmable counts: how many clock cycles the output stays high, and how many it then stays low. The two waveforms are shared by every pin of a GPIO bank. A per-pin choice bit routes one of the two waveforms to that pin's blink level, which the bank then gates and muxes onto its pads.

Software programs the four duration counts and the per-pin choice word through a small synchronous write port, and can read any of them back through a combinational read port. A duration written while a phase is running does not cut that phase short: it is picked up when the counter next reloads. A zero count behaves as a count of one, so neither phase ever vanishes.

Top module: `blink_pair_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both waveforms are high; all five registers read as zero.
- R2: Word addresses 0 (set A high count), 1 (set A low count), 2 (set B high count), 3 (set B low count) and 4 (pin choice word) read back the last value written; addresses 5 to 7 read zero and writes to them change nothing.
- R3: Each waveform is high for its high count in cycles, then low for its low count, repeating without end.
- R4: A count of zero gives a phase of exactly one clock cycle.
- R5: Counts are full 32-bit values; the all-ones value is stored and read back unchanged.
- R6: A count written during a phase leaves that phase's length unchanged; the new count applies from the next phase of that kind.
- R7: The two sets run independently; reprogramming set B does not alter set A's high or low lengths.
- R8: Pin i's blink level equals set B's waveform when bit i of the choice word is 1, and set A's waveform when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe, captured on the rising clock edge |
| reg_waddr | input | 3 | Word address of the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Word address of the read |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| wave_a | output | 1 | Set A waveform |
| wave_b | output | 1 | Set B waveform |
| blink_lvl | output | 32 | Per-pin blink level |

## Verification
A write is visible on the read port one clock edge after the strobe, and the bench reads it half a cycle later with the address already settled. Waveform lengths are measured by sampling at falling edges and counting consecutive equal samples only after one complete falling and rising transition has been seen following the last write, so every counted phase was loaded from the new counts. The mid-phase write is placed in the very cycle a high phase starts, and the high length counted across it must be the old value. Pin levels are compared in every sampled cycle against the two waveform ports, since routing adds no register.

// File: rtl/blink_pkg.sv
package blink_pkg;

    localparam int NUM_SETS = 2;
    localparam int ADDR_W   = 3;

    // Word addresses of the register port. Bit 1 picks the set and bit 0
    // picks high/low count, which the register file decodes directly.
    typedef enum logic [ADDR_W-1:0] {
        ADR_A_HI  = 3'd0,
        ADR_A_LO  = 3'd1,
        ADR_B_HI  = 3'd2,
        ADR_B_LO  = 3'd3,
        ADR_PICK  = 3'd4
    } blink_addr_e;

endpackage

// File: rtl/blink_regs.sv
module blink_regs
    import blink_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_PINS = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr,
    input  logic [ADDR_W-1:0]                  waddr,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic [ADDR_W-1:0]                  raddr,
    output logic [DATA_W-1:0]                  rdata,
    output logic [NUM_SETS-1:0][DATA_W-1:0]    dur_hi,
    output logic [NUM_SETS-1:0][DATA_W-1:0]    dur_lo,
    output logic [NUM_PINS-1:0]                pick
);

    typedef struct packed {
        logic [NUM_SETS-1:0][DATA_W-1:0] hi;
        logic [NUM_SETS-1:0][DATA_W-1:0] lo;
        logic [NUM_PINS-1:0]             pick;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            if (waddr == ADR_PICK) begin
                r_d.pick = wdata[NUM_PINS-1:0];
            end else if (!waddr[2]) begin
                for (int s = 0; s < NUM_SETS; s++) begin
                    if (waddr[1] == s[0]) begin
                        if (waddr[0]) r_d.lo[s] = wdata;
                        else          r_d.hi[s] = wdata;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (raddr == ADR_PICK) begin
            rdata = DATA_W'(r_q.pick);
        end else if (!raddr[2]) begin
            rdata = raddr[0] ? r_q.lo[raddr[1]] : r_q.hi[raddr[1]];
        end
    end

    assign dur_hi = r_q.hi;
    assign dur_lo = r_q.lo;
    assign pick   = r_q.pick;

endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] dur_hi,
    input  logic [CNT_W-1:0] dur_lo,
    output logic             wave
);

    typedef struct packed {
        logic             high;
        logic [CNT_W-1:0] left;   // cycles remaining in phase, minus one
    } tmr_t;

    tmr_t t_d, t_q;

    // Reload value: a zero count behaves as one cycle.
    function automatic logic [CNT_W-1:0] reload(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    always_comb begin
        t_d = t_q;
        if (t_q.left == '0) begin
            t_d.high = !t_q.high;
            t_d.left = reload(t_q.high ? dur_lo : dur_hi);
        end else begin
            t_d.left = t_q.left - 1'b1;
        end
    end

    // Reset enters the high phase; the high count register resets to zero
    // in the same cycle, so its reload value is zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            t_q.high <= 1'b1;
            t_q.left <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign wave = t_q.high;

endmodule

// File: rtl/blink_route.sv
module blink_route
    import blink_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] pick,
    input  logic [NUM_SETS-1:0] waves,
    output logic [NUM_PINS-1:0] lvl
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign lvl[p] = pick[p] ? waves[1] : waves[0];
    end

endmodule

// File: rtl/blink_pair_gen.sv
module blink_pair_gen
    import blink_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [2:0]          reg_waddr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [2:0]          reg_raddr,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                wave_a,
    output logic                wave_b,
    output logic [NUM_PINS-1:0] blink_lvl
);

    logic [NUM_SETS-1:0][DATA_W-1:0] dur_hi_w;
    logic [NUM_SETS-1:0][DATA_W-1:0] dur_lo_w;
    logic [NUM_PINS-1:0]             pick_w;
    logic [NUM_SETS-1:0]             wave_w;

    blink_regs #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .waddr  (reg_waddr),
        .wdata  (reg_wdata),
        .raddr  (reg_raddr),
        .rdata  (reg_rdata),
        .dur_hi (dur_hi_w),
        .dur_lo (dur_lo_w),
        .pick   (pick_w)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        blink_timer #(.CNT_W(DATA_W)) i_tmr (
            .clk    (clk),
            .rst    (rst),
            .dur_hi (dur_hi_w[s]),
            .dur_lo (dur_lo_w[s]),
            .wave   (wave_w[s])
        );
    end

    blink_route #(.NUM_PINS(NUM_PINS)) i_route (
        .pick  (pick_w),
        .waves (wave_w),
        .lvl   (blink_lvl)
    );

    assign wave_a = wave_w[0];
    assign wave_b = wave_w[1];

endmodule

// File: rtl/blink_pair_gen_chk.sv
module blink_pair_gen_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_PINS = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_wr,
    input  logic [2:0]                 reg_waddr,
    input  logic                       wave_a,
    input  logic                       wave_b,
    input  logic [NUM_PINS-1:0]        blink_lvl,
    input  logic [NUM_PINS-1:0]        pick,
    input  logic [1:0][DATA_W-1:0]     dur_hi,
    input  logic [1:0][DATA_W-1:0]     dur_lo
);

    assert_reset_high_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (wave_a && wave_b));

    assert_hi_hold_a_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(wave_a) && ($past(dur_hi[0]) > 1)) |=> wave_a);

    assert_lo_hold_a_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(wave_a) && ($past(dur_lo[0]) > 1)) |=> !wave_a);

    assert_hi_hold_b_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(wave_b) && ($past(dur_hi[1]) > 1)) |=> wave_b);

    assert_lo_hold_b_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(wave_b) && ($past(dur_lo[1]) > 1)) |=> !wave_b);

    assert_unmapped_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_waddr > 3'd4)) |=>
            ($stable(pick) && $stable(dur_hi) && $stable(dur_lo)));

    assert_all_a_R8: assert property (@(posedge clk) disable iff (rst)
        (pick == '0) |-> (blink_lvl == {NUM_PINS{wave_a}}));

    assert_all_b_R8: assert property (@(posedge clk) disable iff (rst)
        (pick == '1) |-> (blink_lvl == {NUM_PINS{wave_b}}));

endmodule

bind blink_pair_gen blink_pair_gen_chk #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_waddr (reg_waddr),
    .wave_a    (wave_a),
    .wave_b    (wave_b),
    .blink_lvl (blink_lvl),
    .pick      (pick_w),
    .dur_hi    (dur_hi_w),
    .dur_lo    (dur_lo_w)
);

// File: tb/test_blink_pair_gen.sv
module test_blink_pair_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        wave_a, wave_b;
    logic [31:0] blink_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    blink_pair_gen i_blink_pair_gen (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .wave_a(wave_a), .wave_b(wave_b), .blink_lvl(blink_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_raddr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    function automatic logic wv(input int s);
        return (s != 0) ? wave_b : wave_a;
    endfunction

    function automatic int eff(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    task automatic measure(input int s, output int hi, output int lo);
        while (wv(s) !== 1'b1) @(negedge clk);
        while (wv(s) !== 1'b0) @(negedge clk);
        while (wv(s) !== 1'b1) @(negedge clk);
        hi = 0;
        while (wv(s) === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (wv(s) === 1'b0) begin lo++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi, lo, n;
        logic [31:0] pat, exp;

        repeat (3) @(negedge clk);
        // R1: high while in reset and in the first cycle after release
        chk("R1 wave_a in reset", 32'(wave_a), 32'd1);
        chk("R1 wave_b in reset", 32'(wave_b), 32'd1);
        rst = 1'b0;
        chk("R1 wave_a after release", 32'(wave_a), 32'd1);
        chk("R1 pins follow A", blink_lvl, 32'hFFFF_FFFF);
        // R4: zero counts toggle every cycle
        @(negedge clk);
        chk("R4 zero count low phase", 32'(wave_a), 32'd0);
        @(negedge clk);
        chk("R4 zero count high again", 32'(wave_b), 32'd1);
        for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'd0, "R1 register reset value");

        // R3 R4 R7: sweep high/low counts on both sets
        for (int h = 0; h < 6; h++) begin
            for (int l = 0; l < 6; l++) begin
                int bh, bl;
                bh = (h + 2) % 6;
                bl = (l * 2 + 1) % 6;
                @(negedge clk);
                wr_reg(3'd0, 32'(h)); wr_reg(3'd1, 32'(l));
                wr_reg(3'd2, 32'(bh)); wr_reg(3'd3, 32'(bl));
                measure(0, hi, lo);
                chk("R3 R4 set A high length", 32'(hi), 32'(eff(h)));
                chk("R3 R4 set A low length", 32'(lo), 32'(eff(l)));
                measure(1, hi, lo);
                chk("R3 R7 set B high length", 32'(hi), 32'(eff(bh)));
                chk("R3 R7 set B low length", 32'(lo), 32'(eff(bl)));
            end
        end

        // R7: reprogramming B leaves A alone
        wr_reg(3'd0, 32'd4); wr_reg(3'd1, 32'd2);
        wr_reg(3'd2, 32'd1); wr_reg(3'd3, 32'd1);
        measure(0, hi, lo);
        chk("R7 A high before B change", 32'(hi), 32'd4);
        wr_reg(3'd2, 32'd7); wr_reg(3'd3, 32'd3);
        measure(0, hi, lo);
        chk("R7 A high after B change", 32'(hi), 32'd4);
        chk("R7 A low after B change", 32'(lo), 32'd2);
        measure(1, hi, lo);
        chk("R7 B high new", 32'(hi), 32'd7);

        // R6: a write in the first high cycle does not cut the phase
        wr_reg(3'd0, 32'd12); wr_reg(3'd1, 32'd2);
        measure(0, hi, lo);
        chk("R6 long high settled", 32'(hi), 32'd12);
        while (wave_a !== 1'b0) @(negedge clk);
        while (wave_a !== 1'b1) @(negedge clk);
        reg_wr = 1'b1; reg_waddr = 3'd0; reg_wdata = 32'd2;
        n = 1;
        @(negedge clk);
        reg_wr = 1'b0;
        while (wave_a === 1'b1) begin n++; @(negedge clk); end
        chk("R6 running phase keeps old length", 32'(n), 32'd12);
        measure(0, hi, lo);
        chk("R6 next phase uses new length", 32'(hi), 32'd2);

        // R8: per-pin routing under several choice words
        wr_reg(3'd0, 32'd1); wr_reg(3'd1, 32'd2);
        wr_reg(3'd2, 32'd3); wr_reg(3'd3, 32'd1);
        for (int k = 0; k < 7; k++) begin
            case (k)
                0: pat = 32'h0000_0000;
                1: pat = 32'hFFFF_FFFF;
                2: pat = 32'hA5A5_5A5A;
                3: pat = 32'h0000_0001;
                4: pat = 32'h8000_0000;
                5: pat = 32'h1234_5678;
                default: pat = 32'hF0F0_0F0F;
            endcase
            wr_reg(3'd4, pat);
            rd_chk(3'd4, pat, "R2 choice word readback");
            for (int c = 0; c < 10; c++) begin
                exp = (pat & {32{wave_b}}) | (~pat & {32{wave_a}});
                chk("R8 pin levels", blink_lvl, exp);
                @(negedge clk);
            end
        end

        // R2: readback and unmapped addresses
        rd_chk(3'd0, 32'd1, "R2 A high readback");
        rd_chk(3'd1, 32'd2, "R2 A low readback");
        rd_chk(3'd2, 32'd3, "R2 B high readback");
        rd_chk(3'd3, 32'd1, "R2 B low readback");
        @(negedge clk);
        wr_reg(3'd5, 32'hDEAD_BEEF); wr_reg(3'd6, 32'h1111_1111); wr_reg(3'd7, 32'h7777_7777);
        for (int a = 5; a < 8; a++) rd_chk(3'(a), 32'd0, "R2 unmapped reads zero");
        rd_chk(3'd0, 32'd1, "R2 A high after unmapped writes");
        rd_chk(3'd1, 32'd2, "R2 A low after unmapped writes");
        rd_chk(3'd2, 32'd3, "R2 B high after unmapped writes");
        rd_chk(3'd3, 32'd1, "R2 B low after unmapped writes");
        rd_chk(3'd4, 32'hF0F0_0F0F, "R2 choice after unmapped writes");

        // R5: full-width count stored
        @(negedge clk);
        wr_reg(3'd3, 32'hFFFF_FFFF);
        rd_chk(3'd3, 32'hFFFF_FFFF, "R5 all-ones count readback");
        wr_reg(3'd1, 32'h8000_0001);
        rd_chk(3'd1, 32'h8000_0001, "R5 wide count readback");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule